// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits on the byte-wide path between a receive MAC and the write port of the receive FIFO. For every frame it decides which bytes go into the FIFO. When the frame ends, it decides whether the frame is kept or flushed, and it reports the conditions that ended the frame. It computes no CRC and does no address matching. It takes the address-match verdict as an input and gets the frame boundaries from the MAC.

When stripping is on, the block holds each byte back by as many bytes as the FCS is long. The trailing check bytes therefore never reach the FIFO. Bytes beyond the length declared in a short length/type field are also suppressed. The block discards frames that collide early, using a threshold that a low-latency option shortens. It flushes runt frames, and it always flushes a runt that has collided. On FIFO overflow it drops the rest of the frame and flushes that frame only. If the lost frame would have been accepted, it adds one to a saturating missed-packet counter.

Top module: `rx_frame_filter`

## Requirements
- R1: `strip_en` is 1 after `rst_n` is released and in the cycle after a `soft_rst` pulse. A `strip_wr` pulse loads `strip_wdata` into it. A frame uses the value of `strip_en` that is present on its first byte.
- R2: With stripping off, every accepted byte appears on `fifo_wdata` with `fifo_wr` one cycle later, in arrival order. `frame_bytes` then equals the frame length.
- R3: With stripping on, the last 4 bytes of a frame are never written. The other bytes are written in order.
- R4: With stripping on, bytes 12 (high) and 13 (low) form a big-endian length/type value L, counted from byte 0. If L < 46, no byte at an index of 14+L or more is written.
- R5: The early-collision threshold is 64 bytes, or 12 bytes when `cfg_low_latency` is 1. A collision flagged on a byte whose index is below the threshold makes the frame flushed.
- R6: A collision on a byte whose index is at or above the threshold sets `frame_late_coll`. Such a frame is not flushed unless R7 or R8 applies.
- R7: A frame shorter than 64 bytes is flushed if it had any collision, or if `cfg_runt_accept` is 0.
- R8: A write that is needed while `fifo_full` is 1 starts overflow. From then on no byte of the frame is written, and the frame ends with `frame_ovf` and `frame_flush` set and `frame_late_coll` clear. The next frame is not affected.
- R9: `missed_cnt` increments by one for each overflowed frame that had `rx_addr_hit` = 1 on its last byte and no collision. It saturates at 255.
- R10: `frame_done` pulses for one cycle, one cycle after the byte that carries `rx_eof`. With it, `frame_bytes` gives the number of bytes written for the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset pulse; sets strip enable |
| strip_wr | input | 1 | Load strip enable from strip_wdata |
| strip_wdata | input | 1 | New strip enable value |
| cfg_low_latency | input | 1 | Use the 12-byte early-collision threshold |
| cfg_runt_accept | input | 1 | Keep runt frames that did not collide |
| rx_valid | input | 1 | A byte is presented this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_coll | input | 1 | Collision seen during this byte |
| rx_addr_hit | input | 1 | Address-match verdict, sampled with the last byte |
| fifo_full | input | 1 | FIFO cannot take a byte this cycle |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| frame_done | output | 1 | End-of-frame status valid |
| frame_flush | output | 1 | Discard the current frame from the FIFO |
| frame_ovf | output | 1 | Frame overflowed |
| frame_late_coll | output | 1 | Frame saw a late collision |
| frame_bytes | output | 12 | Bytes written for the frame |
| missed_cnt | output | 8 | Saturating missed-packet count |
| strip_en | output | 1 | Current strip enable |

## Verification
The hardest state to reach is saturation of the missed-packet counter. It needs hundreds of frames that each overflow, pass the address match and stay free of collisions. The bench reaches it by sending a long series of short frames with `fifo_full` held high from their first byte, so that every frame overflows at once. The other hard case is a collision that counts as late under the low-latency threshold but falls inside a runt frame. The bench places the collision at byte 20 of a 40-byte frame with runt acceptance on, so both rules act on the same frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // End-of-frame verdict carried to the status outputs
    typedef struct packed {
        logic flush;
        logic ovf;
        logic late;
    } rxf_flags_t;

    localparam rxf_flags_t RXF_FLAGS_NONE = '{flush: 1'b0, ovf: 1'b0, late: 1'b0};

endpackage

// File: rtl/rxf_delay_line.sv
module rxf_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        stage_q[g] <= '0;
                else if (shift_en) stage_q[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        stage_q[g] <= '0;
                else if (shift_en) stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX_V = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != MAX_V) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_MISS_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == MAX_V |=> cnt_q == MAX_V);                               // R9
    AST_MISS_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != $past(cnt_q) |-> cnt_q == $past(cnt_q) + 1'b1);          // R9
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 12,
    parameter int MISS_W     = 8,
    parameter int FCS_BYTES  = 4,
    parameter int SLOT_BYTES = 64,
    parameter int LL_BYTES   = 12,
    parameter int MIN_FRAME  = 64,
    parameter int HDR_BYTES  = 14,
    parameter int PAD_LIMIT  = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              strip_wr,
    input  logic              strip_wdata,
    input  logic              cfg_low_latency,
    input  logic              cfg_runt_accept,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_coll,
    input  logic              rx_addr_hit,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              frame_done,
    output logic              frame_flush,
    output logic              frame_ovf,
    output logic              frame_late_coll,
    output logic [CNT_W-1:0]  frame_bytes,
    output logic [MISS_W-1:0] missed_cnt,
    output logic              strip_en
);
    localparam int LEN_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] POS_MAX   = '1;
    localparam logic [CNT_W-1:0] THR_SLOT  = CNT_W'(SLOT_BYTES);
    localparam logic [CNT_W-1:0] THR_LL    = CNT_W'(LL_BYTES);
    localparam logic [CNT_W-1:0] FCS_C     = CNT_W'(FCS_BYTES);
    localparam logic [CNT_W-1:0] HDR_C     = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] LEN_HI_AT = CNT_W'(HDR_BYTES - 2);
    localparam logic [CNT_W-1:0] LEN_LO_AT = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] MIN_C     = CNT_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] PAD_C     = LEN_W'(PAD_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0]  pos;
        logic [CNT_W-1:0]  wcnt;
        logic [DATA_W-1:0] len_hi;
        logic [LEN_W-1:0]  len_val;
        logic              has_pad;
        logic              strip_f;
        logic              ecoll;
        logic              lcoll;
        logic              ovf;
        logic              strip_en;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        rxf_flags_t        flags;
        logic [CNT_W-1:0]  bytes;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] held_byte;
    logic              miss_inc_d;

    rxf_delay_line #(
        .W     (DATA_W),
        .DEPTH (FCS_BYTES)
    ) u_fcs_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_valid),
        .din      (rx_data),
        .dout     (held_byte)
    );

    rxf_sat_counter #(
        .W (MISS_W)
    ) u_missed (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_inc_d),
        .count (missed_cnt)
    );

    // Next-state computation
    always_comb begin
        logic [CNT_W-1:0] pos_cur, thr, held_idx, pad_end, total;
        logic             strip_cur, coll_now, ecoll_n, lcoll_n, ovf_n;
        logic             keep_held, want, blocked, any_coll, runt, last;

        st_d       = st_q;
        st_d.wr    = 1'b0;
        st_d.done  = 1'b0;
        st_d.flags = RXF_FLAGS_NONE;
        miss_inc_d = 1'b0;

        // strip enable register
        if (soft_rst)      st_d.strip_en = 1'b1;
        else if (strip_wr) st_d.strip_en = strip_wdata;

        pos_cur   = rx_sof ? '0 : st_q.pos;
        strip_cur = rx_sof ? st_q.strip_en : st_q.strip_f;
        thr       = cfg_low_latency ? THR_LL : THR_SLOT;
        coll_now  = rx_valid && rx_coll;

        ecoll_n = (rx_sof ? 1'b0 : st_q.ecoll) | (coll_now && (pos_cur <  thr));
        lcoll_n = (rx_sof ? 1'b0 : st_q.lcoll) | (coll_now && (pos_cur >= thr));

        // byte leaving the FCS hold stage has index pos_cur - FCS_BYTES
        held_idx  = pos_cur - FCS_C;
        pad_end   = HDR_C + st_q.len_val[CNT_W-1:0];
        keep_held = !(st_q.has_pad && !rx_sof && (held_idx >= pad_end));
        want      = strip_cur ? ((pos_cur >= FCS_C) && keep_held) : 1'b1;

        blocked = (rx_sof ? 1'b0 : st_q.ovf) | ecoll_n;
        ovf_n   = (rx_sof ? 1'b0 : st_q.ovf) | (rx_valid && want && !blocked && fifo_full);

        total    = (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
        any_coll = ecoll_n | lcoll_n;
        runt     = total < MIN_C;
        last     = rx_valid && rx_eof;

        if (rx_valid) begin
            st_d.pos     = total;
            st_d.strip_f = strip_cur;
            st_d.ecoll   = ecoll_n;
            st_d.lcoll   = lcoll_n;
            st_d.ovf     = ovf_n;
            st_d.wr      = want && !blocked && !fifo_full;
            st_d.wdata   = strip_cur ? held_byte : rx_data;
            st_d.wcnt    = (rx_sof ? '0 : st_q.wcnt) + CNT_W'(st_d.wr);
            if (rx_sof) st_d.has_pad = 1'b0;

            // length/type field capture
            if (pos_cur == LEN_HI_AT) st_d.len_hi = rx_data;
            if (pos_cur == LEN_LO_AT) begin
                st_d.len_val = {st_q.len_hi, rx_data};
                st_d.has_pad = {st_q.len_hi, rx_data} < PAD_C;
            end
        end

        if (last) begin
            st_d.done        = 1'b1;
            st_d.bytes       = st_d.wcnt;
            st_d.flags.ovf   = ovf_n;
            st_d.flags.late  = lcoll_n && !ovf_n;
            st_d.flags.flush = ovf_n | ecoll_n | (runt && (any_coll || !cfg_runt_accept));
            miss_inc_d       = ovf_n && rx_addr_hit && !any_coll;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.strip_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_wr         = st_q.wr;
    assign fifo_wdata      = st_q.wdata;
    assign frame_done      = st_q.done;
    assign frame_flush     = st_q.flags.flush;
    assign frame_ovf       = st_q.flags.ovf;
    assign frame_late_coll = st_q.flags.late;
    assign frame_bytes     = st_q.bytes;
    assign strip_en        = st_q.strip_en;

    AST_WR_ONLY_WITH_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(!fifo_full && rx_valid));                       // R8
    AST_OVF_FORCES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf |-> frame_flush && !frame_late_coll);                   // R8
    AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_flush || frame_ovf || frame_late_coll) |-> frame_done);    // R10
    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(rx_valid && rx_eof));                        // R10
    AST_SOFT_RST_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> strip_en);                                           // R1
endmodule

// File: tb/rx_frame_filter_bench.sv
module rx_frame_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 0, strip_wr = 0, strip_wdata = 0;
    logic       cfg_low_latency = 0, cfg_runt_accept = 0;
    logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_coll = 0, rx_addr_hit = 0;
    logic [7:0] rx_data = '0;
    logic       fifo_full = 0;
    logic       fifo_wr, frame_done, frame_flush, frame_ovf, frame_late_coll, strip_en;
    logic [7:0] fifo_wdata, missed_cnt;
    logic [11:0] frame_bytes;

    int checks = 0, errors = 0;
    int wr_n = 0;
    logic [7:0] wr_buf [512];
    bit   got_done = 0, d_flush = 0, d_ovf = 0, d_late = 0;
    int   d_bytes = 0;
    int   exp_miss = 0;

    always #5 clk = ~clk;

    rx_frame_filter u_rx_frame_filter (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .strip_wr(strip_wr),
        .strip_wdata(strip_wdata), .cfg_low_latency(cfg_low_latency),
        .cfg_runt_accept(cfg_runt_accept), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_coll(rx_coll), .rx_addr_hit(rx_addr_hit),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .frame_done(frame_done), .frame_flush(frame_flush), .frame_ovf(frame_ovf),
        .frame_late_coll(frame_late_coll), .frame_bytes(frame_bytes),
        .missed_cnt(missed_cnt), .strip_en(strip_en)
    );

    always @(negedge clk) begin
        if (fifo_wr) begin
            if (wr_n < 512) wr_buf[wr_n] = fifo_wdata;
            wr_n++;
        end
        if (frame_done) begin
            got_done = 1;
            d_flush  = frame_flush;
            d_ovf    = frame_ovf;
            d_late   = frame_late_coll;
            d_bytes  = int'(frame_bytes);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int lenf);
        if (i == 12) return 8'(lenf >> 8);
        if (i == 13) return 8'(lenf);
        return 8'(i * 7 + 3);
    endfunction

    // Sends one frame; coll_pos < 0 means no collision; fifo_full high on indices lo..hi
    task automatic send_frame(input int n, input int lenf, input int coll_pos,
                              input int full_lo, input int full_hi, input bit hit);
        @(negedge clk);
        wr_n = 0; got_done = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid    = 1;
            rx_data     = pat(i, lenf);
            rx_sof      = (i == 0);
            rx_eof      = (i == n - 1);
            rx_coll     = (i == coll_pos);
            rx_addr_hit = hit;
            fifo_full   = (i >= full_lo) && (i <= full_hi);
            @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_coll = 0; fifo_full = 0;
        #1;
    endtask

    // Compares the captured writes with the expected byte index range 0..cnt-1
    task automatic check_writes(input int cnt, input int lenf, input string req);
        bit ok = (wr_n == cnt);
        for (int k = 0; k < cnt && k < wr_n; k++)
            if (wr_buf[k] !== pat(k, lenf)) ok = 0;
        chk(ok, req, "written bytes", wr_n, cnt);
    endtask

    task automatic set_strip(input bit v);
        @(negedge clk); strip_wr = 1; strip_wdata = v;
        @(negedge clk); strip_wr = 0; #1;
        chk(strip_en == v, "R1", "strip load", int'(strip_en), int'(v));
    endtask

    task automatic t_reset;
        #1;
        chk(fifo_wr == 0 && frame_done == 0, "R10", "idle after reset", int'(fifo_wr), 0);
        chk(missed_cnt == 0, "R9", "missed after reset", int'(missed_cnt), 0);
        chk(strip_en == 1, "R1", "strip after reset", int'(strip_en), 1);
    endtask

    task automatic t_soft_reset;
        set_strip(0);
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0; #1;
        chk(strip_en == 1, "R1", "strip after soft reset", int'(strip_en), 1);
    endtask

    task automatic t_passthrough;
        set_strip(0);
        send_frame(70, 16'h0800, -1, -1, -1, 1);
        check_writes(70, 16'h0800, "R2");
        chk(got_done && d_bytes == 70, "R10", "byte count no strip", d_bytes, 70);
        chk(!d_flush, "R2", "long frame kept", int'(d_flush), 0);
    endtask

    task automatic t_strip_fcs;
        set_strip(1);
        send_frame(80, 16'h0800, -1, -1, -1, 1);
        check_writes(76, 16'h0800, "R3");
        chk(d_bytes == 76, "R3", "byte count FCS stripped", d_bytes, 76);
    endtask

    task automatic t_strip_pad;
        set_strip(1);
        send_frame(64, 20, -1, -1, -1, 1);
        check_writes(34, 20, "R4");
        chk(d_bytes == 34 && !d_flush, "R4", "pad stripped count", d_bytes, 34);
    endtask

    task automatic t_collisions;
        set_strip(0);
        cfg_low_latency = 0;
        send_frame(100, 16'h0800, 40, -1, -1, 1);
        chk(d_flush && !d_late, "R5", "early coll normal flush", int'(d_flush), 1);
        send_frame(100, 16'h0800, 70, -1, -1, 1);
        chk(!d_flush && d_late, "R6", "late coll normal", int'(d_late), 1);
        cfg_low_latency = 1;
        send_frame(100, 16'h0800, 40, -1, -1, 1);
        chk(!d_flush && d_late, "R6", "late coll low latency", int'(d_late), 1);
        send_frame(100, 16'h0800, 8, -1, -1, 1);
        chk(d_flush && !d_late, "R5", "early coll low latency", int'(d_flush), 1);
        cfg_low_latency = 0;
    endtask

    task automatic t_runts;
        set_strip(0);
        cfg_runt_accept = 0;
        send_frame(40, 16'h0800, -1, -1, -1, 1);
        chk(d_flush, "R7", "runt flushed", int'(d_flush), 1);
        cfg_runt_accept = 1;
        send_frame(40, 16'h0800, -1, -1, -1, 1);
        chk(!d_flush, "R7", "runt accepted", int'(d_flush), 0);
        cfg_low_latency = 1;
        send_frame(40, 16'h0800, 20, -1, -1, 1);
        chk(d_flush && d_late, "R7", "collided runt flushed", int'(d_flush), 1);
        cfg_low_latency = 0;
        cfg_runt_accept = 0;
    endtask

    task automatic t_overflow;
        set_strip(0);
        send_frame(80, 16'h0800, -1, 30, 35, 1);
        exp_miss++;
        check_writes(30, 16'h0800, "R8");
        chk(d_ovf && d_flush, "R8", "overflow flagged", int'(d_ovf), 1);
        chk(int'(missed_cnt) == exp_miss, "R9", "missed on hit", int'(missed_cnt), exp_miss);
        send_frame(80, 16'h0800, -1, 30, 35, 0);
        chk(int'(missed_cnt) == exp_miss, "R9", "no miss without hit", int'(missed_cnt), exp_miss);
        send_frame(100, 16'h0800, 70, 30, 31, 1);
        chk(d_ovf && !d_late, "R8", "late suppressed on ovf", int'(d_late), 0);
        chk(int'(missed_cnt) == exp_miss, "R9", "no miss with coll", int'(missed_cnt), exp_miss);
        send_frame(70, 16'h0800, -1, -1, -1, 1);
        check_writes(70, 16'h0800, "R8");
        chk(!d_ovf && !d_flush, "R8", "next frame clean", int'(d_ovf), 0);
    endtask

    task automatic t_saturate;
        set_strip(0);
        for (int f = 0; f < 260; f++) begin
            send_frame(20, 16'h0800, -1, 0, 19, 1);
            if (exp_miss < 255) exp_miss++;
        end
        chk(missed_cnt == 8'd255 && exp_miss == 255, "R9", "missed saturates",
            int'(missed_cnt), 255);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_soft_reset();
        t_passthrough();
        t_strip_fcs();
        t_strip_pad();
        t_collisions();
        t_runts();
        t_overflow();
        t_saturate();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule